// File: doc/BRIEF.md
# VXLAN Tunnel Termination Parser

This block sits on the receive path and inspects every Ethernet frame that arrives as a byte stream, one byte per cycle, framed by start and end markers. It decides whether the frame is a VXLAN-encapsulated packet whose outer IPv4 destination is one of this device's own tunnel endpoint addresses. If it is, the outer Ethernet, IPv4, UDP and VXLAN headers are removed in-line, 50 bytes in total. Later stages then receive only the inner Ethernet frame, tagged with a terminated flag and the 24-bit VXLAN network identifier.

Every other frame leaves unchanged, still encapsulated where applicable, so that it is forwarded on its outer headers. The block holds back the first 50 bytes of each frame in a fixed delay line while it makes the decision. A frame that is not terminated therefore leaves exactly 50 cycles after it arrives. A small table of four local endpoint addresses, each with its own enable bit, is written through a simple write port. A table write only takes effect when the next frame starts, so a frame is always judged against one consistent table.

Top module: `vxlan_term_parser`

## Requirements
- R1: A frame that is not terminated leaves unchanged, with every byte and both markers in the original order, and its first byte leaves exactly 50 cycles after it entered.
- R2: Termination requires the outer IPv4 destination, bytes 30 to 33 (most significant byte first), to equal the address of an enabled table entry.
- R3: Termination requires the outer UDP destination port, bytes 36 and 37, to equal 4789. Any other port passes the frame through.
- R4: Termination requires the EtherType, bytes 12 and 13, to be 0x0800, byte 14 to be 0x45 (IPv4 with a five-word header) and the protocol, byte 23, to be 17.
- R5: Termination requires bit 3 of the VXLAN flags byte, byte 42, to be set. If it is clear, the frame passes through.
- R6: A terminated frame leaves without its first 50 bytes. Its first output byte is input byte 50 and carries the start marker, and the end marker stays on the last byte.
- R7: On every byte of a terminated frame, out_term is 1. The VNI, taken from bytes 46 to 48 with byte 46 as the most significant, appears on out_vni from the first output byte onwards. Pass-through bytes show out_term 0 and out_vni 0.
- R8: The table holds 4 entries. An entry whose enable bit is clear never matches, even if its address does.
- R9: A table write made while a frame is arriving does not affect that frame. It applies from the next frame start.
- R10: A frame of 50 bytes or fewer is never terminated and passes through whole.
- R11: While reset is held, and on the cycle after reset, no output byte is valid.
- R12: Frames may follow each other with no idle cycle between them, and each is judged on its own headers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid, held high for every byte of a frame |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Input byte |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 2 | Table entry to write |
| cfg_addr | input | 32 | Local endpoint IPv4 address |
| cfg_valid | input | 1 | Enable bit for the written entry |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | First byte of an output frame |
| out_eof | output | 1 | Last byte of an output frame |
| out_data | output | 8 | Output byte |
| out_term | output | 1 | Frame was a terminated tunnel |
| out_vni | output | 24 | VXLAN network identifier of a terminated frame |

## Verification
The bench feeds complete frames that differ from a matching frame in exactly one field: the destination address, the port, the EtherType, the header length byte, the protocol or the I flag. A design that skips any one of these comparisons would strip a frame it should have passed through. Frames of exactly 50 bytes and of fewer than 50 bytes that otherwise match are sent to catch a design that terminates with no inner frame left, or that keeps a stale verdict from an earlier frame. The bench also checks a disabled entry with a matching address, and a table write made in the middle of a frame, which a design would get wrong by applying the write at once. Back-to-back frames of opposite verdicts catch a design whose verdict or strip count leaks from one frame into the next.

// File: rtl/vxt_pkg.sv
package vxt_pkg;

    localparam int HDR_BYTES   = 50;   // 14 Ethernet + 20 IPv4 + 8 UDP + 8 VXLAN
    localparam int OFF_ETYPE   = 12;
    localparam int OFF_VIHL    = 14;
    localparam int OFF_PROTO   = 23;
    localparam int OFF_DIP     = 30;
    localparam int OFF_DPORT   = 36;
    localparam int OFF_VXFLAGS = 42;
    localparam int OFF_VNI     = 46;

    localparam logic [15:0] ETYPE_IPV4  = 16'h0800;
    localparam logic [7:0]  VIHL_PLAIN  = 8'h45;
    localparam logic [7:0]  PROTO_UDP   = 8'd17;
    localparam logic [15:0] VXLAN_PORT  = 16'd4789;
    localparam int          IFLAG_BIT   = 3;

    typedef struct packed {
        logic       valid;
        logic       sof;
        logic       eof;
        logic [7:0] data;
    } beat_t;

    typedef struct packed {
        logic        term;
        logic [23:0] vni;
    } verdict_t;

    function automatic logic outer_hdr_ok(
        input logic [15:0] etype,
        input logic [7:0]  vihl,
        input logic [7:0]  proto,
        input logic [15:0] dport,
        input logic [7:0]  flags
    );
        return (etype == ETYPE_IPV4) && (vihl == VIHL_PLAIN) &&
               (proto == PROTO_UDP) && (dport == VXLAN_PORT) &&
               flags[IFLAG_BIT];
    endfunction

endpackage

// File: rtl/vxt_delay_line.sv
module vxt_delay_line
    import vxt_pkg::*;
#(
    parameter int DEPTH = HDR_BYTES
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t d,
    output beat_t q
);
    beat_t stage [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage[i] <= '0;
                end else if (i == 0) begin
                    stage[i] <= d;
                end else begin
                    stage[i] <= stage[(i == 0) ? 0 : i - 1];
                end
            end
        end
    endgenerate

    assign q = stage[DEPTH-1];

endmodule

// File: rtl/vxt_ltable.sv
module vxt_ltable #(
    parameter int ENTRIES = 4,
    parameter int AW      = 32,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_valid,
    input  logic          frame_start,
    input  logic [AW-1:0] lookup,
    output logic          hit
);
    logic [ENTRIES-1:0][AW-1:0] shd_addr, act_addr;
    logic [ENTRIES-1:0]         shd_v, act_v, hit_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            shd_addr <= '0;
            shd_v    <= '0;
            act_addr <= '0;
            act_v    <= '0;
        end else begin
            if (wr_en) begin
                shd_addr[wr_idx] <= wr_addr;
                shd_v[wr_idx]    <= wr_valid;
            end
            if (frame_start) begin
                act_addr <= shd_addr;
                act_v    <= shd_v;
            end
        end
    end

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
            assign hit_vec[e] = act_v[e] && (act_addr[e] == lookup);
        end
    endgenerate

    assign hit = |hit_vec;

    // R9: the table used for matching only moves at a frame start
    p_active_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> ($stable(act_v) && $stable(act_addr)));

endmodule

// File: rtl/vxt_hdr_parser.sv
module vxt_hdr_parser
    import vxt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  beat_t       in,
    input  logic        hit,
    output logic [31:0] dip,
    output verdict_t    verdict
);
    localparam int CW = $clog2(HDR_BYTES + 1);
    localparam logic [CW-1:0] LAST = CW'(HDR_BYTES - 1);
    localparam logic [CW-1:0] FULL = CW'(HDR_BYTES);

    logic [CW-1:0] cnt_q, idx;
    logic [15:0]   etype_q, dport_q;
    logic [7:0]    vihl_q, proto_q, flags_q;
    logic [23:0]   vni_q;
    logic [31:0]   dip_q;

    assign idx = in.sof ? '0 : cnt_q;
    assign dip = dip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            etype_q <= '0;
            dport_q <= '0;
            vihl_q  <= '0;
            proto_q <= '0;
            flags_q <= '0;
            vni_q   <= '0;
            dip_q   <= '0;
            verdict <= '0;
        end else if (in.valid) begin
            if (in.eof)           cnt_q <= '0;
            else if (idx != FULL) cnt_q <= idx + 1'b1;

            case (int'(idx))
                OFF_ETYPE, OFF_ETYPE + 1:            etype_q <= {etype_q[7:0], in.data};
                OFF_VIHL:                            vihl_q  <= in.data;
                OFF_PROTO:                           proto_q <= in.data;
                OFF_DIP, OFF_DIP + 1,
                OFF_DIP + 2, OFF_DIP + 3:            dip_q   <= {dip_q[23:0], in.data};
                OFF_DPORT, OFF_DPORT + 1:            dport_q <= {dport_q[7:0], in.data};
                OFF_VXFLAGS:                         flags_q <= in.data;
                OFF_VNI, OFF_VNI + 1, OFF_VNI + 2:   vni_q   <= {vni_q[15:0], in.data};
                default: ;
            endcase

            if (idx == LAST) begin
                verdict.term <= !in.eof && hit &&
                                outer_hdr_ok(etype_q, vihl_q, proto_q, dport_q, flags_q);
                verdict.vni  <= vni_q;
            end else if (in.eof && idx < LAST) begin
                verdict <= '0;
            end
        end
    end

    // R6: the header byte counter never runs past the strip length
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);

endmodule

// File: rtl/vxlan_term_parser.sv
module vxlan_term_parser
    import vxt_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_eof,
    input  logic [7:0]    in_data,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic [31:0]   cfg_addr,
    input  logic          cfg_valid,
    output logic          out_valid,
    output logic          out_sof,
    output logic          out_eof,
    output logic [7:0]    out_data,
    output logic          out_term,
    output logic [23:0]   out_vni
);
    localparam int CW = $clog2(HDR_BYTES + 1);
    localparam logic [CW-1:0] FULL = CW'(HDR_BYTES);

    beat_t       in_beat, dl_q;
    verdict_t    verdict;
    logic [31:0] dip;
    logic        hit, term_eff, strip;
    logic [23:0] vni_eff;
    logic [CW-1:0] oidx_q, oidx;
    logic        oterm_q;
    logic [23:0] ovni_q;

    assign in_beat = '{valid: in_valid, sof: in_sof, eof: in_eof, data: in_data};

    vxt_ltable #(.ENTRIES(ENTRIES), .AW(32)) u_table (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_addr(cfg_addr), .wr_valid(cfg_valid),
        .frame_start(in_valid && in_sof),
        .lookup(dip), .hit(hit)
    );

    vxt_hdr_parser u_parse (
        .clk(clk), .rst(rst), .in(in_beat), .hit(hit),
        .dip(dip), .verdict(verdict)
    );

    vxt_delay_line #(.DEPTH(HDR_BYTES)) u_delay (
        .clk(clk), .rst(rst), .d(in_beat), .q(dl_q)
    );

    // output side: the verdict is latched as the frame's first byte emerges
    assign oidx     = dl_q.sof ? '0 : oidx_q;
    assign term_eff = dl_q.sof ? verdict.term : oterm_q;
    assign vni_eff  = dl_q.sof ? verdict.vni  : ovni_q;
    assign strip    = term_eff && (oidx < FULL);

    assign out_valid = dl_q.valid && !strip;
    assign out_sof   = out_valid && (term_eff ? (oidx == FULL) : dl_q.sof);
    assign out_eof   = out_valid && dl_q.eof;
    assign out_data  = dl_q.data;
    assign out_term  = out_valid && term_eff;
    assign out_vni   = out_term ? vni_eff : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            oidx_q  <= '0;
            oterm_q <= 1'b0;
            ovni_q  <= '0;
        end else if (dl_q.valid) begin
            if (oidx != FULL) oidx_q <= oidx + 1'b1;
            oterm_q <= term_eff;
            ovni_q  <= vni_eff;
        end
    end

    // R11: nothing leaves in the cycle after reset
    p_quiet_after_reset_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    // R7: the terminated flag does not change inside a frame
    p_term_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_sof && $past(out_valid)) |-> (out_term == $past(out_term)));

    // R6: once a terminated frame has started, its bytes keep arriving with no gap
    p_term_contig_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_term && !out_eof) |=> out_valid);

endmodule

// File: tb/tb_vxlan_term_parser.sv
`timescale 1ns/1ps
module tb_vxlan_term_parser;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_sof, in_eof;
    logic [7:0]  in_data;
    logic        cfg_we, cfg_valid;
    logic [1:0]  cfg_idx;
    logic [31:0] cfg_addr;
    logic        out_valid, out_sof, out_eof, out_term;
    logic [7:0]  out_data;
    logic [23:0] out_vni;

    always #2 clk = ~clk;   // 250 MHz

    vxlan_term_parser dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_addr(cfg_addr), .cfg_valid(cfg_valid),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data),
        .out_term(out_term), .out_vni(out_vni)
    );

    int checks = 0;
    int fails  = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [7:0]  fb [0:255];
    logic [7:0]  sa [0:255];
    int          flen, salen;
    logic [7:0]  ob [0:511];
    logic        osof [0:511];
    logic        oeof [0:511];
    logic        oterm [0:511];
    logic [23:0] ovni [0:511];
    longint      ocyc [0:511];
    int          on;
    longint      in_sof_cyc;
    bit          mid_wr = 0;
    logic [31:0] mid_addr = '0;

    always @(negedge clk) begin
        if (out_valid === 1'b1 && on < 512) begin
            ob[on] = out_data; osof[on] = out_sof; oeof[on] = out_eof;
            oterm[on] = out_term; ovni[on] = out_vni; ocyc[on] = cyc;
            on++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic build(input logic [31:0] dip, input logic [15:0] dport,
                         input logic [7:0] flg, input logic [23:0] vni,
                         input logic [15:0] etype, input logic [7:0] vihl,
                         input logic [7:0] proto, input int inner);
        for (int i = 0; i < 256; i++) fb[i] = 8'h00;
        for (int i = 0; i < 6; i++) begin fb[i] = 8'h10 + 8'(i); fb[6+i] = 8'h20 + 8'(i); end
        fb[12] = etype[15:8]; fb[13] = etype[7:0];
        fb[14] = vihl; fb[22] = 8'd64; fb[23] = proto;
        fb[26] = 8'd192; fb[27] = 8'd168; fb[28] = 8'd1; fb[29] = 8'd9;
        fb[30] = dip[31:24]; fb[31] = dip[23:16]; fb[32] = dip[15:8]; fb[33] = dip[7:0];
        fb[34] = 8'hC3; fb[35] = 8'h51;
        fb[36] = dport[15:8]; fb[37] = dport[7:0];
        fb[42] = flg;
        fb[46] = vni[23:16]; fb[47] = vni[15:8]; fb[48] = vni[7:0];
        for (int i = 0; i < inner; i++) fb[50+i] = 8'hA0 ^ 8'(i * 7);
        flen = 50 + inner;
    endtask

    task automatic tbl_write(input logic [1:0] idx, input logic [31:0] a, input logic v);
        @(posedge clk); #1;
        cfg_we = 1; cfg_idx = idx; cfg_addr = a; cfg_valid = v;
        @(posedge clk); #1;
        cfg_we = 0;
    endtask

    task automatic send(input bit idle_after);
        for (int i = 0; i < flen; i++) begin
            @(posedge clk); #1;
            in_valid = 1; in_data = fb[i]; in_sof = (i == 0); in_eof = (i == flen - 1);
            if (i == 0) in_sof_cyc = cyc;
            cfg_we = mid_wr && (i == 5);
            cfg_idx = 2'd2; cfg_addr = mid_addr; cfg_valid = 1'b1;
        end
        if (idle_after) begin
            @(posedge clk); #1;
            in_valid = 0; in_sof = 0; in_eof = 0; cfg_we = 0;
        end
    endtask

    task automatic drain();
        repeat (60) @(posedge clk);
        #1;
    endtask

    // compare captured output against fb[start .. start+n-1]
    task automatic expect_frame(input string req, input bit term,
                                input logic [23:0] vni, input int start, input int n);
        bit same = 1;
        check(on == n, req, "output byte count", on, n);
        for (int i = 0; i < n && i < on; i++) if (ob[i] !== fb[start+i]) same = 0;
        check(same, req, "output bytes", on > 0 ? ob[0] : 0, fb[start]);
        if (on > 0 && on == n) begin
            check(osof[0] === 1'b1 && oeof[n-1] === 1'b1, req, "frame markers",
                  {osof[0], oeof[n-1]}, 2'b11);
            check(oterm[0] === term, req, "terminated flag", oterm[0], term);
            check(ovni[0] === (term ? vni : 24'h0), req, "vni", ovni[0], term ? vni : 24'h0);
            if (!term)
                check(ocyc[0] - in_sof_cyc == 50, req, "pass-through latency",
                      ocyc[0] - in_sof_cyc, 50);
        end
    endtask

    task automatic run(input string req, input bit term, input logic [23:0] vni);
        on = 0;
        send(1);
        drain();
        if (term) expect_frame(req, 1, vni, 50, flen - 50);
        else      expect_frame(req, 0, vni, 0, flen);
    endtask

    localparam logic [31:0] LOC0 = 32'h0A000001;
    localparam logic [31:0] LOC1 = 32'h0A000002;
    localparam logic [31:0] LOC3 = 32'h0A000004;
    localparam logic [31:0] LOCM = 32'h0A000033;

    task automatic t_reset();
        on = 0;
        rst = 1; in_valid = 0; in_sof = 0; in_eof = 0; in_data = 0;
        cfg_we = 0; cfg_idx = 0; cfg_addr = 0; cfg_valid = 0;
        repeat (4) @(posedge clk);
        #1; check(out_valid === 1'b0, "R11", "out_valid during reset", out_valid, 0);
        rst = 0;
        @(posedge clk); #1;
        check(out_valid === 1'b0, "R11", "out_valid after reset", out_valid, 0);
    endtask

    task automatic t_terminate();
        tbl_write(2'd0, LOC0, 1'b1);
        build(LOC0, 16'd4789, 8'h08, 24'hABCDEF, 16'h0800, 8'h45, 8'd17, 20);
        run("R6", 1, 24'hABCDEF);
        build(LOC0, 16'd4789, 8'h08, 24'h000123, 16'h0800, 8'h45, 8'd17, 64);
        run("R7", 1, 24'h000123);
    endtask

    task automatic t_fields();
        build(32'h0A000009, 16'd4789, 8'h08, 24'h1, 16'h0800, 8'h45, 8'd17, 20);
        run("R2", 0, 0);
        build(LOC0, 16'd4790, 8'h08, 24'h1, 16'h0800, 8'h45, 8'd17, 20);
        run("R3", 0, 0);
        build(LOC0, 16'd4789, 8'h08, 24'h1, 16'h86DD, 8'h45, 8'd17, 20);
        run("R4", 0, 0);
        build(LOC0, 16'd4789, 8'h08, 24'h1, 16'h0800, 8'h46, 8'd17, 20);
        run("R4", 0, 0);
        build(LOC0, 16'd4789, 8'h08, 24'h1, 16'h0800, 8'h45, 8'd6, 20);
        run("R4", 0, 0);
        build(LOC0, 16'd4789, 8'hF7, 24'h1, 16'h0800, 8'h45, 8'd17, 20);
        run("R5", 0, 0);
        build(32'hFFFFFFFF, 16'd80, 8'h00, 24'h0, 16'h0806, 8'h00, 8'd0, 10);
        run("R1", 0, 0);
    endtask

    task automatic t_table();
        tbl_write(2'd1, LOC1, 1'b0);
        build(LOC1, 16'd4789, 8'h08, 24'h55AA11, 16'h0800, 8'h45, 8'd17, 12);
        run("R8", 0, 0);
        tbl_write(2'd3, LOC3, 1'b1);
        build(LOC3, 16'd4789, 8'h08, 24'h55AA11, 16'h0800, 8'h45, 8'd17, 12);
        run("R8", 1, 24'h55AA11);
        mid_wr = 1; mid_addr = LOCM;
        build(LOCM, 16'd4789, 8'h08, 24'h0F0F0F, 16'h0800, 8'h45, 8'd17, 12);
        run("R9", 0, 0);
        mid_wr = 0;
        run("R9", 1, 24'h0F0F0F);
    endtask

    task automatic t_short();
        build(LOC0, 16'd4789, 8'h08, 24'h777777, 16'h0800, 8'h45, 8'd17, 0);
        run("R10", 0, 0);
        build(LOC0, 16'd4789, 8'h08, 24'h777777, 16'h0800, 8'h45, 8'd17, 0);
        flen = 30;
        run("R10", 0, 0);
    endtask

    task automatic t_back_to_back();
        int na;
        bit same = 1;
        on = 0;
        build(LOC0, 16'd4789, 8'h08, 24'h13579B, 16'h0800, 8'h45, 8'd17, 16);
        for (int i = 0; i < flen; i++) sa[i] = fb[i];
        salen = flen;
        send(0);
        build(LOC0, 16'd4790, 8'h08, 24'h13579B, 16'h0800, 8'h45, 8'd17, 16);
        send(1);
        drain();
        na = salen - 50;
        check(on == na + flen, "R12", "combined byte count", on, na + flen);
        if (on == na + flen) begin
            for (int i = 0; i < na; i++) if (ob[i] !== sa[50+i]) same = 0;
            for (int i = 0; i < flen; i++) if (ob[na+i] !== fb[i]) same = 0;
            check(same, "R12", "combined bytes", ob[0], sa[50]);
            check(oterm[0] === 1'b1 && oterm[na] === 1'b0, "R12", "per-frame verdicts",
                  {oterm[0], oterm[na]}, 2'b10);
            check(osof[na] === 1'b1 && oeof[na-1] === 1'b1, "R12", "frame boundary",
                  {osof[na], oeof[na-1]}, 2'b11);
            check(ovni[0] === 24'h13579B && ovni[na] === 24'h0, "R12", "vni per frame",
                  ovni[0], 24'h13579B);
        end
    endtask

    bit finished = 0;

    initial begin
        t_reset();
        t_terminate();
        t_fields();
        t_table();
        t_short();
        t_back_to_back();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule